// File: doc/BRIEF.md
# Receiver Load Detection and Termination Controller

This block controls eight serial output channels. For each channel it runs a receiver-load probe and selects the termination and drive state of that channel's input and output. A probe starts when software or a strap drives the channel's reset bit from 0 to 1, provided the channel is powered and detection is enabled. While the probe runs, the output is held on its weak pull-up. After a fixed number of system clocks, the block samples a digitised line comparator and latches whether a load is present.

Outside a probe, a fixed priority table sets the terminations. Power-down comes first, then the channel reset bit, then the probe in progress, then detect enable, and last the latched result. The result and the signal-detect flag together decide whether the output terminates at 50 ohm and drives, or is squelched onto its pull-up. The analog comparator and the termination devices lie outside the block. They appear only as a digital input and as encoded select outputs.

Top module: `rxdet_bank`

## Requirements
- R1: After system reset every latched detect result reads 0, no probe is running, and a channel reset bit that is already 1 does not start a probe.
- R2: With power-down high, the input and output selects of that channel are both 00 (Hi-Z) and the driver enable is 0, whatever the other inputs are.
- R3: With power-down low and the channel reset bit at 0, the input select is 00, the output select is 01 (2K pull-up) and the driver is off, even when detect enable is 0.
- R4: A 0-to-1 change of the channel reset bit, with detect enable 1 and power-down 0, starts a probe. The latched result clears to 0 at the same edge. During the probe the input select is 00, the output select is 01 and the driver is off.
- R5: A channel reset bit held steady at 0 or at 1 starts no probe and leaves the latched result unchanged, whatever the comparator does.
- R6: A probe lasts TIMEOUT clocks. The comparator is sampled only at the clock edge that ends the probe, and the latched result takes that sampled value (1 = load present). Earlier comparator values have no effect.
- R7: With detect enable 0, the input select is 10 (50 ohm). The output select is 10 with the driver on when signal detect is 1, and 01 with the driver off otherwise. A reset-bit rising edge starts no probe in this mode.
- R8: With detect enable 1 and a latched result of 0, the channel is inactive: input select 00, output select 01, driver off.
- R9: With detect enable 1 and a latched result of 1, the input select is 10. The output select is 10 with the driver on only while signal detect is 1. Otherwise the output is squelched to 01 with the driver off.
- R10: Power-down going high, detect enable going low, or the reset bit going low during a probe ends the probe and leaves the result at 0. A later rising edge starts a full TIMEOUT-long probe from the beginning.
- R11: Each channel is probed and mapped only from its own inputs. Activity on one channel leaves the others' results and selects unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low system reset |
| pwrDown | input | NUM_CH | Per-channel power-down, 1 = off |
| detEn | input | NUM_CH | Per-channel receiver detect enable |
| chanRst | input | NUM_CH | Per-channel reset bit, rising edge starts a probe |
| lineLoad | input | NUM_CH | Sampled line comparator, 1 = load sensed |
| sigDet | input | NUM_CH | Signal-detect flag, 1 = input above threshold |
| inTerm | output | 2*NUM_CH | Input termination select per channel (00 Hi-Z, 01 2K, 10 50 ohm) |
| outTerm | output | 2*NUM_CH | Output termination select per channel (same encoding) |
| drvEn | output | NUM_CH | Output driver enable per channel |
| loadFound | output | NUM_CH | Latched detect result per channel |

## Verification
The termination selects and the driver enable are combinational from the inputs and the registered state. They are due in the same cycle as a static input change, and the bench reads them one full clock after applying a vector. A probe starts at the first edge that sees the rising reset bit, and the result clears at that edge. The result appears after the TIMEOUT-th following edge. The bench therefore checks for a still-clear result after TIMEOUT-1 edges and for the latched value one edge later. It changes the comparator only at the last possible moment, to show that only the final edge counts.

// File: rtl/rxdet_pkg.sv
package rxdet_pkg;
  typedef enum logic [1:0] {
    TERM_HIZ    = 2'b00,
    TERM_PULL2K = 2'b01,
    TERM_R50    = 2'b10
  } term_e;

  typedef struct packed {
    logic start;    // probe begins this edge
    logic sample;   // comparator is captured this edge
    logic probing;  // probe in progress
  } rdStrobe_t;
endpackage

// File: rtl/rd_ctrl.sv
module rd_ctrl
  import rxdet_pkg::*;
#(
  parameter int TIMEOUT = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwrDown,
  input  logic       detEn,
  input  logic       chanRst,
  output rdStrobe_t  strobe
);
  localparam int CW = $clog2(TIMEOUT + 1);
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT - 1);

  logic          prevRst;
  logic          busy;
  logic [CW-1:0] cnt;
  logic          startNow;
  logic          abortNow;
  logic          expireNow;

  assign startNow  = chanRst && !prevRst && detEn && !pwrDown;
  assign abortNow  = pwrDown || !detEn || !chanRst;
  assign expireNow = busy && !abortNow && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prevRst <= 1'b1;
      busy    <= 1'b0;
      cnt     <= '0;
    end else begin
      prevRst <= chanRst;
      if (startNow) begin
        busy <= 1'b1;
        cnt  <= '0;
      end else if (busy && abortNow) begin
        busy <= 1'b0;
        cnt  <= '0;
      end else if (expireNow) begin
        busy <= 1'b0;
        cnt  <= '0;
      end else if (busy) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign strobe.start   = startNow;
  assign strobe.sample  = expireNow;
  assign strobe.probing = busy;

  a_r4_start_enters_probe: assert property (@(posedge clk) disable iff (!rst_n)
    startNow |=> busy);
  a_r10_abort_ends_probe: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && abortNow) |=> !busy);
  a_r6_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt < CW'(TIMEOUT)));
  a_r6_sample_ends_probe: assert property (@(posedge clk) disable iff (!rst_n)
    expireNow |=> !busy);
endmodule

// File: rtl/rd_path.sv
module rd_path
  import rxdet_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  rdStrobe_t  strobe,
  input  logic       pwrDown,
  input  logic       detEn,
  input  logic       chanRst,
  input  logic       lineLoad,
  input  logic       sigDet,
  output logic [1:0] inTerm,
  output logic [1:0] outTerm,
  output logic       drvEn,
  output logic       loadFound
);
  term_e inSel;
  term_e outSel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              loadFound <= 1'b0;
    else if (strobe.start)   loadFound <= 1'b0;
    else if (strobe.sample)  loadFound <= lineLoad;
  end

  always_comb begin
    inSel  = TERM_HIZ;
    outSel = TERM_HIZ;
    drvEn  = 1'b0;
    if (pwrDown) begin
      inSel  = TERM_HIZ;
      outSel = TERM_HIZ;
    end else if (!chanRst || strobe.probing) begin
      outSel = TERM_PULL2K;
    end else if (!detEn || loadFound) begin
      inSel = TERM_R50;
      if (sigDet) begin
        outSel = TERM_R50;
        drvEn  = 1'b1;
      end else begin
        outSel = TERM_PULL2K;
      end
    end else begin
      outSel = TERM_PULL2K;
    end
  end

  assign inTerm  = inSel;
  assign outTerm = outSel;

  a_r5_result_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !(strobe.start || strobe.sample) |=> $stable(loadFound));
  a_r4_probe_clears: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.start |=> !loadFound);
  a_r9_drive_needs_signal: assert property (@(posedge clk) disable iff (!rst_n)
    drvEn |-> (sigDet && outTerm == 2'b10 && inTerm == 2'b10));
  a_r4_probe_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.probing |-> (!drvEn && outTerm != 2'b10));
endmodule

// File: rtl/rxdet_bank.sv
module rxdet_bank
  import rxdet_pkg::*;
#(
  parameter int NUM_CH  = 8,
  parameter int TIMEOUT = 64
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_CH-1:0]     pwrDown,
  input  logic [NUM_CH-1:0]     detEn,
  input  logic [NUM_CH-1:0]     chanRst,
  input  logic [NUM_CH-1:0]     lineLoad,
  input  logic [NUM_CH-1:0]     sigDet,
  output logic [2*NUM_CH-1:0]   inTerm,
  output logic [2*NUM_CH-1:0]   outTerm,
  output logic [NUM_CH-1:0]     drvEn,
  output logic [NUM_CH-1:0]     loadFound
);
  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    rdStrobe_t chStrobe;

    rd_ctrl #(.TIMEOUT(TIMEOUT)) i_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .pwrDown (pwrDown[g]),
      .detEn   (detEn[g]),
      .chanRst (chanRst[g]),
      .strobe  (chStrobe)
    );

    rd_path i_path (
      .clk       (clk),
      .rst_n     (rst_n),
      .strobe    (chStrobe),
      .pwrDown   (pwrDown[g]),
      .detEn     (detEn[g]),
      .chanRst   (chanRst[g]),
      .lineLoad  (lineLoad[g]),
      .sigDet    (sigDet[g]),
      .inTerm    (inTerm[2*g +: 2]),
      .outTerm   (outTerm[2*g +: 2]),
      .drvEn     (drvEn[g]),
      .loadFound (loadFound[g])
    );
  end
endmodule

// File: tb/test_rxdet_bank.sv
module test_rxdet_bank;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 8;
  localparam int PT  = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NCH-1:0] pwrDown, detEn, chanRst, lineLoad, sigDet;
  logic [2*NCH-1:0] inTerm, outTerm;
  logic [NCH-1:0] drvEn, loadFound;

  int vecs = 0;
  int errs = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rxdet_bank #(.NUM_CH(NCH), .TIMEOUT(PT)) i_rxdet_bank (
    .clk(clk), .rst_n(rst_n), .pwrDown(pwrDown), .detEn(detEn),
    .chanRst(chanRst), .lineLoad(lineLoad), .sigDet(sigDet),
    .inTerm(inTerm), .outTerm(outTerm), .drvEn(drvEn), .loadFound(loadFound)
  );

  // {pd, en, sig, in0, out0, drv0, in1, out1, drv1}; ch0 holds a found load, ch1 none
  localparam int NV = 7;
  localparam logic [12:0] VEC [NV] = '{
    {3'b011, 2'b10, 2'b10, 1'b1, 2'b00, 2'b01, 1'b0},
    {3'b010, 2'b10, 2'b01, 1'b0, 2'b00, 2'b01, 1'b0},
    {3'b001, 2'b10, 2'b10, 1'b1, 2'b10, 2'b10, 1'b1},
    {3'b000, 2'b10, 2'b01, 1'b0, 2'b10, 2'b01, 1'b0},
    {3'b111, 2'b00, 2'b00, 1'b0, 2'b00, 2'b00, 1'b0},
    {3'b100, 2'b00, 2'b00, 1'b0, 2'b00, 2'b00, 1'b0},
    {3'b011, 2'b10, 2'b10, 1'b1, 2'b00, 2'b01, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errs++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    pwrDown = '0; detEn = '1; chanRst = '1; lineLoad = '0; sigDet = '0;
    tick(3);
    rst_n = 1'b1;
    tick(PT + 2);
    // R1 and R8: no result, inactive selects, static 1 reset bit starts nothing
    chk("R1 result", loadFound, 8'h00);
    chk("R8 inTerm", inTerm, 16'h0000);
    chk("R8 outTerm", outTerm, 16'h5555);
    // R3: reset bit low overrides detect-disable
    chanRst = '0; detEn = '0; sigDet = '1;
    tick(1);
    chk("R3 inTerm", inTerm, 16'h0000);
    chk("R3 outTerm", outTerm, 16'h5555);
    chk("R3 drvEn", drvEn, 8'h00);
    // R4 / R6: probe, comparator flips only before the last edge
    detEn = '1; lineLoad = 8'h02;
    chanRst = '1;
    tick(1);
    chk("R4 cleared", loadFound, 8'h00);
    chk("R4 inTerm", inTerm, 16'h0000);
    chk("R4 outTerm", outTerm, 16'h5555);
    chk("R4 drvEn", drvEn, 8'h00);
    tick(PT - 1);
    chk("R6 not yet", loadFound, 8'h00);
    lineLoad = 8'h01;
    tick(1);
    chk("R6 latched", loadFound, 8'h01);
    chk("R9 drive ch0", drvEn, 8'h01);
    // table of static mappings (R2, R7, R8, R9)
    for (int v = 0; v < NV; v++) begin
      pwrDown = {NCH{VEC[v][12]}};
      detEn   = {NCH{VEC[v][11]}};
      sigDet  = {NCH{VEC[v][10]}};
      tick(1);
      chk($sformatf("R2/R7/R8/R9 vec%0d ch0", v),
          {inTerm[1:0], outTerm[1:0], drvEn[0]}, VEC[v][9:5]);
      chk($sformatf("R2/R7/R8/R9 vec%0d ch1", v),
          {inTerm[3:2], outTerm[3:2], drvEn[1]}, VEC[v][4:0]);
      chk($sformatf("R5 vec%0d result", v), loadFound, 8'h01);
    end
    // R5: static reset bit, comparator toggling
    pwrDown = '0; detEn = '1; sigDet = '1; lineLoad = '1;
    tick(3 * PT);
    chk("R5 static one", loadFound, 8'h01);
    chanRst = '0;
    tick(2 * PT);
    chk("R5 static zero", loadFound, 8'h01);
    // R7: rising edge with detect disabled starts nothing
    detEn = '0;
    chanRst = '1;
    tick(PT + 2);
    chk("R7 no probe", loadFound, 8'h01);
    chk("R7 inTerm", inTerm, 16'hAAAA);
    chk("R7 outTerm", outTerm, 16'hAAAA);
    chk("R7 drvEn", drvEn, 8'hFF);
    // R10: abort by power-down, then full restart
    detEn = '1; chanRst = '0;
    tick(1);
    chanRst = '1;
    tick(1);
    chk("R10 cleared", loadFound, 8'h00);
    tick(2);
    pwrDown = '1;
    tick(1);
    pwrDown = '0;
    tick(PT + 2);
    chk("R10 aborted", loadFound, 8'h00);
    chanRst = '0;
    tick(1);
    chanRst = '1;
    tick(PT);
    chk("R10 full window", loadFound, 8'h00);
    tick(1);
    chk("R10 restarted", loadFound, 8'hFF);
    // R11: probe channel 3 alone with no load
    lineLoad = '0;
    chanRst[3] = 1'b0;
    tick(1);
    chanRst[3] = 1'b1;
    tick(PT + 1);
    chk("R11 isolation", loadFound, 8'hF7);
    chk("R11 ch3 inactive", {inTerm[7:6], outTerm[7:6], drvEn[3]}, 5'b00010);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule